// File: doc/BRIEF.md
# Cascaded Multi-Match Prioritizer

This block takes a wide vector of match lines and reports every asserted line, one line per cycle, lowest index first. The vector is split into equal slices, and each slice is handled by its own stage. The stage that holds the lowest line indices has the highest priority and reports first. Enable passes along the chain from a stage to the next stage only when the current stage has nothing left to grant. The result is that matches come out in global ascending order, even though each slice is sequenced on its own.

A `start` pulse captures the match vector and a limit on how many matches to report. From the cycle after the pulse, the block drives three outputs:
- a one-hot grant over all lines;
- the encoded index of the granted line, built from the stage number and the local bit position, together with a valid flag;
- a `done` flag once reporting is over.

Reporting ends when the last stage is exhausted or when the limit has been reached.

Top module: `mm_cascade`

## Requirements
- R1: After reset, `grant` is all zero, and `index_valid` and `done` are both low.
- R2: On a cycle with `start` high, the block captures `match_in` and `limit`. Changes to `match_in` after that cycle have no effect on the grants of the run.
- R3: Across a run, every captured set line is granted exactly once, in strictly ascending index order. No grant is repeated.
- R4: `grant` is one-hot while `index_valid` is high and zero otherwise. Granted lines in the same stage come out on consecutive cycles, one per cycle.
- R5: A stage with no captured set line costs exactly one cycle without a grant before the next stage takes over.
- R6: `index` equals `{stage number, local bit position}`. With power-of-two slices this is the line number of the granted bit.
- R7: A run stops after `limit` grants. `done` rises on the cycle after the last of those grants.
- R8: `done` rises on the cycle after the last stage finishes. It then stays high, with no grant, until the next `start`.
- R9: A `limit` of zero gives `done` on the cycle after `start` and no grant.
- R10: A `start` during a run abandons that run and begins a new one from the newly captured vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Capture match vector and limit, begin a run |
| match_in | input | STAGES*SLICE | Match lines, bit 0 highest priority |
| limit | input | clog2(STAGES*SLICE+1) | Maximum number of grants in the run |
| grant | output | STAGES*SLICE | One-hot grant of the current line |
| index | output | SW+LW | Encoded index of the granted line |
| index_valid | output | 1 | A grant is presented this cycle |
| done | output | 1 | Run finished |

## Verification
Grant outputs are combinational from state that the `start` edge loads. The first grant is therefore due on the cycle after `start`, and each later grant or empty-stage gap takes one further cycle. `done` is due one cycle after the final grant or gap. The bench builds, from the captured vector and the limit, an exact expected list of indices and an exact count of busy cycles. It samples at every falling edge, so each grant is matched to the cycle it is due in, and `done` is checked against the computed cycle count.

// File: rtl/mm_cascade.sv
module mm_cascade #(
  parameter int STAGES = 8,
  parameter int SLICE  = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [STAGES*SLICE-1:0]                match_in,
  input  logic [$clog2(STAGES*SLICE+1)-1:0]      limit,
  output logic [STAGES*SLICE-1:0]                grant,
  output logic [((STAGES > 1) ? $clog2(STAGES) : 1) + ((SLICE > 1) ? $clog2(SLICE) : 1)-1:0] index,
  output logic                                   index_valid,
  output logic                                   done
);
  localparam int N  = STAGES * SLICE;
  localparam int CW = $clog2(N + 1);
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int LW = (SLICE > 1) ? $clog2(SLICE) : 1;

  logic [N-1:0]      pend;
  logic [SW-1:0]     cur;
  logic [CW-1:0]     cnt, lim;
  logic              busy, done_q;
  logic [STAGES-1:0] oe, last_bit;
  logic [LW-1:0]     lidx [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [SLICE-1:0] sl, low;
    logic             en;
    assign sl  = pend[s*SLICE +: SLICE];
    assign low = sl & (~sl + 1'b1);
    assign en  = busy && (cur == SW'(s));
    assign oe[s] = en && (|sl);
    assign last_bit[s] = ((sl & ~low) == '0);
    assign grant[s*SLICE +: SLICE] = oe[s] ? low : '0;
    always_comb begin
      lidx[s] = '0;
      for (int b = SLICE - 1; b >= 0; b--)
        if (sl[b]) lidx[s] = LW'(b);
    end
  end

  assign index_valid = |oe;
  assign index       = {cur, lidx[cur]};
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; cur <= '0; cnt <= '0; lim <= '0; busy <= 1'b0; done_q <= 1'b0;
    end else if (start) begin
      pend <= match_in; lim <= limit; cnt <= '0; cur <= '0;
      busy <= (limit != '0); done_q <= (limit == '0);
    end else if (busy) begin
      if (index_valid) begin
        pend <= pend & ~grant;
        cnt  <= cnt + 1'b1;
        if (cnt + 1'b1 == lim || (last_bit[cur] && cur == SW'(STAGES - 1))) begin
          busy <= 1'b0; done_q <= 1'b1;
        end else if (last_bit[cur]) cur <= cur + 1'b1;
      end else if (cur == SW'(STAGES - 1)) begin
        busy <= 1'b0; done_q <= 1'b1;
      end else cur <= cur + 1'b1;
    end
  end

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (index_valid == (grant != '0)));
  p_index_hits_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    index_valid |-> grant[index]);
  p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (index_valid && !start) |=> (!index_valid || index > $past(index)));
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !index_valid);
  p_under_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    index_valid |-> cnt < lim);
  p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && limit == '0) |=> (done && !index_valid));
endmodule

// File: tb/mm_cascade_tb.sv
module mm_cascade_tb;
  localparam int STAGES = 8, SLICE = 8, N = 64, CW = 7, IW = 6;
  logic clk = 0, rst_n = 0, start = 0;
  logic [N-1:0] match_in = '0, grant;
  logic [CW-1:0] limit = '0;
  logic [IW-1:0] index;
  logic index_valid, done;
  int tests = 0, fails = 0;

  mm_cascade #(.STAGES(STAGES), .SLICE(SLICE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .match_in(match_in), .limit(limit),
    .grant(grant), .index(index), .index_valid(index_valid), .done(done));

  always #4 clk = ~clk;

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] m, input logic [CW-1:0] l);
    @(negedge clk); start = 1; match_in = m; limit = l;
    @(negedge clk); start = 0;
  endtask

  task automatic run_case(input logic [N-1:0] m, input int l, input bit disturb, input string req);
    int exp_idx[N]; int ne = 0, ecyc = 0, got = 0, cyc = 0; bit seq_ok = 1, oh_ok = 1;
    for (int s = 0; s < STAGES && ne < l; s++) begin
      if (m[s*SLICE +: SLICE] == '0) ecyc++;
      else for (int b = 0; b < SLICE && ne < l; b++)
        if (m[s*SLICE + b]) begin exp_idx[ne] = s*SLICE + b; ne++; ecyc++; end
    end
    pulse(m, CW'(l));
    if (disturb) match_in = ~m;
    while (!done && cyc < N + STAGES + 4) begin
      if (index_valid) begin
        if (grant != (64'd1 << index)) oh_ok = 0;
        if (got >= ne || int'(index) != exp_idx[got]) seq_ok = 0;
        got++;
      end else if (grant != '0) oh_ok = 0;
      cyc++;
      @(negedge clk);
    end
    check(seq_ok && got == ne, {req, " R3 sequence"}, got, ne);
    check(oh_ok, {req, " R4/R6 grant vs index"}, 0, 0);
    check(cyc == ecyc, {req, " R5 busy cycles"}, cyc, ecyc);
    check(done, {req, " R8 done"}, done, 1);
    @(negedge clk);
    check(done && !index_valid && grant == '0, {req, " R8 done held quiet"}, grant, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(grant == '0 && !index_valid && !done, "R1 reset state", {index_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    run_case(64'h58, 64, 0, "R4 single stage");
    run_case(64'h8000_0100_0000_0081, 64, 0, "R3 spread");
    run_case(64'h8000_0000_0000_0000, 64, 0, "R5 only last line");
    run_case(64'h0, 64, 0, "R5 no match");
    run_case('1, 64, 0, "R4 all set");
    run_case(64'hF0F0_0000_1234_0001, 3, 0, "R7 limit three");
    run_case(64'hFF00, 8, 0, "R7 limit equals count");
    run_case(64'h0103_0000_0000_00A0, 64, 1, "R2 input ignored");
    run_case(64'h1, 1, 0, "R7 limit one");
    pulse(64'hFF, 0);
    check(done && !index_valid, "R9 zero limit", done, 1);
    pulse('1, 64);
    repeat (3) @(negedge clk);
    run_case(64'h0000_4000_0000_0002, 64, 0, "R10 restart");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule